// File: doc/BRIEF.md
# Lane-Rate Band Selector and Programmer

This block turns a per-lane bit rate, given in Mbps, into the 6-bit high-speed frequency-range code that a MIPI D-PHY receiver needs. It then asks a test-port sequencer to write that code into the PHY register that controls lane-0 high-speed reception. The code is found by walking an ordered list of 39 rate ceilings, lowest first, one entry per clock. The first ceiling at or above the requested rate wins. A rate above every ceiling takes the last entry.

Once the code is known, the block raises a request toward the sequencer. The request carries a fixed register selector and a data byte that holds the code at a bit offset. The request stays up until the sequencer acknowledges it. The block then keeps the monitor byte that came back with the acknowledge and pulses a completion flag for one cycle.

Control is a three-state machine.
- `ST_IDLE` takes the transition *accept* on a start pulse.
- `ST_SCAN` takes *step* while the current ceiling is below the rate.
- `ST_SCAN` takes *settle* into `ST_WRITE` once an entry matches or the list is exhausted.
- `ST_WRITE` takes *ack* back to `ST_IDLE` when the sequencer answers.

Top module: `rate_band_prog`

## Requirements
- R1: After reset, the outputs are in these states:
  - `busy`, `seq_req` and `done` are 0.
  - `band_code` is 0.
  - `mon_byte` is 0.
- R2: The selected code is that of the lowest list entry whose ceiling is greater than or equal to the rate. The ceilings run 90, 100, 110, 130, 140, 150, 170, 180, 200, 220, 240, 250, 270, 300, 330, 360, 400, 450, 500, 550, 600, 650, 700, 750, 800, 850, 900, 950, 1000, 1050, 1100, 1150, 1200, 1250, 1300, 1350, 1400, 1450 and 1500. Their codes, in the same order, are 00, 10, 20, 01, 11, 21, 02, 12, 22, 03, 13, 23, 04, 14, 05, 15, 25, 06, 16, 07, 17, 08, 18, 09, 19, 29, 39, 0a, 1a, 2a, 3a, 0b, 1b, 2b, 3b, 0c, 1c, 2c and 3c (hex).
- R3: A rate above 1500 selects the last entry, code 0x3c.
- R4: A ceiling is inclusive. Rate 90 gives 0x00 and 91 gives 0x10. Rate 1000 gives 0x1a and 1100 gives 0x3a.
- R5: The search spends one clock per entry. If the start pulse is sampled at edge E, and the matching entry is at index k (0-based), then `seq_req` rises after edge E+k+1.
- R6: While `seq_req` is high:
  - `seq_code` is 0x44.
  - `seq_data` holds the code in bits 6..1, with bits 7 and 0 at zero.
  - Both `seq_code` and `seq_data`, and `seq_req` itself, stay unchanged until `seq_done` is sampled high.
- R7: A start pulse that arrives while `busy` is high is ignored. It does not change the rate being searched or the resulting code.
- R8: In the cycle after `seq_done` is sampled high during a request, the following all hold:
  - `done` is high for exactly one cycle.
  - `mon_byte` equals the `seq_mon` value presented with `seq_done`.
  - `seq_req` is low.
- R9: `busy` is high from the cycle after an accepted start until the cycle in which `done` is high, where `busy` is low. `band_code` then shows the selected code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search, sampled while idle |
| rate_mbps | input | RATE_W (12) | Lane rate in Mbps, sampled with start |
| seq_req | output | 1 | Write request toward the test-port sequencer |
| seq_code | output | 8 | Register selector for the write |
| seq_data | output | 8 | Data byte for the write |
| seq_done | input | 1 | Sequencer acknowledge, one cycle |
| seq_mon | input | 8 | Monitor byte returned with seq_done |
| busy | output | 1 | Search or write in progress |
| band_code | output | 6 | Most recently selected range code |
| mon_byte | output | 8 | Monitor byte from the last write |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions on request stability and on the completion pulse rely on the sequencer behaving in two ways. First, it pulses `seq_done` only while `seq_req` is high. Second, it holds `seq_done` for a single cycle. The bench's sequencer model answers only after it has seen the request. It drives `seq_done` for one cycle and clears it at the next falling edge, with a varying response delay.

The start-ignored property assumes `start` is a clean synchronous signal. The bench drives it only on falling edges, including deliberate pulses during both the search and the write.

// File: rtl/rate_band_pkg.sv
package rate_band_pkg;
    localparam int NUM_BANDS = 39;
    localparam int CODE_W    = 6;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = $clog2(NUM_BANDS);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_WRITE = 2'd2
    } prog_state_t;
endpackage

// File: rtl/rb_rom.sv
module rb_rom
    import rate_band_pkg::*;
#(
    parameter int RATE_W = 12
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [RATE_W-1:0] ceiling,
    output logic [CODE_W-1:0] code
);
    // ceilings ascend; code low nibble is the coarse band, upper bits the sub-step
    always_comb begin
        unique case (idx)
            6'd0:  begin ceiling = RATE_W'(90);   code = 6'h00; end
            6'd1:  begin ceiling = RATE_W'(100);  code = 6'h10; end
            6'd2:  begin ceiling = RATE_W'(110);  code = 6'h20; end
            6'd3:  begin ceiling = RATE_W'(130);  code = 6'h01; end
            6'd4:  begin ceiling = RATE_W'(140);  code = 6'h11; end
            6'd5:  begin ceiling = RATE_W'(150);  code = 6'h21; end
            6'd6:  begin ceiling = RATE_W'(170);  code = 6'h02; end
            6'd7:  begin ceiling = RATE_W'(180);  code = 6'h12; end
            6'd8:  begin ceiling = RATE_W'(200);  code = 6'h22; end
            6'd9:  begin ceiling = RATE_W'(220);  code = 6'h03; end
            6'd10: begin ceiling = RATE_W'(240);  code = 6'h13; end
            6'd11: begin ceiling = RATE_W'(250);  code = 6'h23; end
            6'd12: begin ceiling = RATE_W'(270);  code = 6'h04; end
            6'd13: begin ceiling = RATE_W'(300);  code = 6'h14; end
            6'd14: begin ceiling = RATE_W'(330);  code = 6'h05; end
            6'd15: begin ceiling = RATE_W'(360);  code = 6'h15; end
            6'd16: begin ceiling = RATE_W'(400);  code = 6'h25; end
            6'd17: begin ceiling = RATE_W'(450);  code = 6'h06; end
            6'd18: begin ceiling = RATE_W'(500);  code = 6'h16; end
            6'd19: begin ceiling = RATE_W'(550);  code = 6'h07; end
            6'd20: begin ceiling = RATE_W'(600);  code = 6'h17; end
            6'd21: begin ceiling = RATE_W'(650);  code = 6'h08; end
            6'd22: begin ceiling = RATE_W'(700);  code = 6'h18; end
            6'd23: begin ceiling = RATE_W'(750);  code = 6'h09; end
            6'd24: begin ceiling = RATE_W'(800);  code = 6'h19; end
            6'd25: begin ceiling = RATE_W'(850);  code = 6'h29; end
            6'd26: begin ceiling = RATE_W'(900);  code = 6'h39; end
            6'd27: begin ceiling = RATE_W'(950);  code = 6'h0a; end
            6'd28: begin ceiling = RATE_W'(1000); code = 6'h1a; end
            6'd29: begin ceiling = RATE_W'(1050); code = 6'h2a; end
            6'd30: begin ceiling = RATE_W'(1100); code = 6'h3a; end
            6'd31: begin ceiling = RATE_W'(1150); code = 6'h0b; end
            6'd32: begin ceiling = RATE_W'(1200); code = 6'h1b; end
            6'd33: begin ceiling = RATE_W'(1250); code = 6'h2b; end
            6'd34: begin ceiling = RATE_W'(1300); code = 6'h3b; end
            6'd35: begin ceiling = RATE_W'(1350); code = 6'h0c; end
            6'd36: begin ceiling = RATE_W'(1400); code = 6'h1c; end
            6'd37: begin ceiling = RATE_W'(1450); code = 6'h2c; end
            6'd38: begin ceiling = RATE_W'(1500); code = 6'h3c; end
            default: begin ceiling = RATE_W'(1500); code = 6'h3c; end
        endcase
    end
endmodule

// File: rtl/rb_scan.sv
module rb_scan
    import rate_band_pkg::*;
#(
    parameter int RATE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [RATE_W-1:0] rate_in,
    input  logic              run,
    output logic              hit,
    output logic [CODE_W-1:0] code
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANDS - 1);

    logic [RATE_W-1:0] rate_q;
    logic [IDX_W-1:0]  idx_q;
    logic [RATE_W-1:0] ceiling;

    rb_rom #(.RATE_W(RATE_W)) u_rom (
        .idx     (idx_q),
        .ceiling (ceiling),
        .code    (code)
    );

    // match on an inclusive ceiling, or saturate on the final entry
    assign hit = run && ((rate_q <= ceiling) || (idx_q == LAST_IDX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            rate_q <= rate_in;
            idx_q  <= '0;
        end else if (run && !hit) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX);                                   // R3
    AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(rate_q));                             // R7
endmodule

// File: rtl/rb_pack.sv
module rb_pack
    import rate_band_pkg::*;
#(
    parameter int FIELD_LSB = 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [BYTE_W-1:0] data_byte
);
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        if (i >= FIELD_LSB && i < FIELD_LSB + CODE_W) begin : g_field
            assign data_byte[i] = code[i - FIELD_LSB];
        end else begin : g_zero
            assign data_byte[i] = 1'b0;
        end
    end
endmodule

// File: rtl/rate_band_prog.sv
module rate_band_prog
    import rate_band_pkg::*;
#(
    parameter int              RATE_W    = 12,
    parameter int              FIELD_LSB = 1,
    parameter logic [BYTE_W-1:0] REG_SEL = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] rate_mbps,
    output logic              seq_req,
    output logic [BYTE_W-1:0] seq_code,
    output logic [BYTE_W-1:0] seq_data,
    input  logic              seq_done,
    input  logic [BYTE_W-1:0] seq_mon,
    output logic              busy,
    output logic [CODE_W-1:0] band_code,
    output logic [BYTE_W-1:0] mon_byte,
    output logic              done
);
    prog_state_t state_q, state_d;

    logic              scan_load;
    logic              scan_run;
    logic              scan_hit;
    logic [CODE_W-1:0] scan_code;
    logic [CODE_W-1:0] band_q;
    logic [BYTE_W-1:0] mon_q;
    logic              done_q;

    rb_scan #(.RATE_W(RATE_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (scan_load),
        .rate_in (rate_mbps),
        .run     (scan_run),
        .hit     (scan_hit),
        .code    (scan_code)
    );

    rb_pack #(.FIELD_LSB(FIELD_LSB)) u_pack (
        .code      (band_q),
        .data_byte (seq_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: accept, step, settle, ack
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_SCAN;
            ST_SCAN:  if (scan_hit) state_d = ST_WRITE;
            ST_WRITE: if (seq_done) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            band_q <= '0;
            mon_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_WRITE) && seq_done;
            if (scan_hit) band_q <= scan_code;
            if ((state_q == ST_WRITE) && seq_done) mon_q <= seq_mon;
        end
    end

    // outputs
    always_comb begin
        scan_load = (state_q == ST_IDLE) && start;
        scan_run  = (state_q == ST_SCAN);
        seq_req   = (state_q == ST_WRITE);
        seq_code  = REG_SEL;
        busy      = (state_q != ST_IDLE);
        band_code = band_q;
        mon_byte  = mon_q;
        done      = done_q;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req && !seq_done) |=> (seq_req && $stable(seq_data) && $stable(seq_code)));  // R6
    AST_FIELD_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req |-> (seq_data[0] == 1'b0 && seq_data[BYTE_W-1] == 1'b0));                 // R6
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(seq_req && seq_done));                                             // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                                  // R8
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !seq_req));                                                    // R9
endmodule

// File: tb/rate_band_prog_test.sv
`timescale 1ns/1ps
module rate_band_prog_test;
    localparam int RW = 12;

    localparam int BT [39] = '{90, 100, 110, 130, 140, 150, 170, 180, 200, 220,
                               240, 250, 270, 300, 330, 360, 400, 450, 500, 550,
                               600, 650, 700, 750, 800, 850, 900, 950, 1000, 1050,
                               1100, 1150, 1200, 1250, 1300, 1350, 1400, 1450, 1500};
    localparam int BC [39] = '{'h00, 'h10, 'h20, 'h01, 'h11, 'h21, 'h02, 'h12, 'h22, 'h03,
                               'h13, 'h23, 'h04, 'h14, 'h05, 'h15, 'h25, 'h06, 'h16, 'h07,
                               'h17, 'h08, 'h18, 'h09, 'h19, 'h29, 'h39, 'h0a, 'h1a, 'h2a,
                               'h3a, 'h0b, 'h1b, 'h2b, 'h3b, 'h0c, 'h1c, 'h2c, 'h3c};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [RW-1:0] rate_mbps = '0;
    logic          seq_req;
    logic [7:0]    seq_code, seq_data;
    logic          seq_done = 1'b0;
    logic [7:0]    seq_mon = '0;
    logic          busy;
    logic [5:0]    band_code;
    logic [7:0]    mon_byte;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rate_band_prog uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rate_mbps(rate_mbps),
        .seq_req(seq_req), .seq_code(seq_code), .seq_data(seq_data),
        .seq_done(seq_done), .seq_mon(seq_mon), .busy(busy),
        .band_code(band_code), .mon_byte(mon_byte), .done(done)
    );

    function automatic int ref_index(int rate);
        for (int i = 0; i < 39; i++) if (rate <= BT[i]) return i;
        return 38;
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    // rate: requested rate; dly: sequencer answer delay; poke: cycle (after
    // start) at which to pulse start again with a different rate, 0 = none
    task automatic run_one(int rate, int dly, int poke);
        int k = ref_index(rate);
        int exp_code = BC[k];
        string tag = (rate > 1500) ? "R3" : "R2";
        int cnt = 0;
        logic [7:0] mon;
        @(negedge clk);
        start = 1'b1;
        rate_mbps = RW'(rate);
        @(negedge clk);
        start = 1'b0;
        rate_mbps = RW'(4000 - rate);
        cnt = 1;
        check("R9 busy after start", int'(busy), 1);
        while (!seq_req && cnt < 60) begin
            if (cnt == poke) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cnt++;
        end
        check("R5 request latency", cnt, k + 2);
        check("R6 register selector", int'(seq_code), 'h44);
        check({tag, " code in data byte"}, int'(seq_data), exp_code << 1);
        for (int d = 0; d < dly; d++) begin
            if (d == 0 && poke != 0) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R6 request held", int'(seq_req), 1);
            check("R6 data held", int'(seq_data), exp_code << 1);
        end
        mon = 8'(rate * 7 + 3);
        seq_done = 1'b1;
        seq_mon = mon;
        @(negedge clk);
        seq_done = 1'b0;
        seq_mon = 8'h00;
        check("R8 done pulse", int'(done), 1);
        check("R8 monitor byte", int'(mon_byte), int'(mon));
        check("R8 request dropped", int'(seq_req), 0);
        check("R9 busy low at done", int'(busy), 0);
        check({tag, " band code"}, int'(band_code), exp_code);
        @(negedge clk);
        check("R8 done single cycle", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy reset", int'(busy), 0);
        check("R1 req reset", int'(seq_req), 0);
        check("R1 done reset", int'(done), 0);
        check("R1 code reset", int'(band_code), 0);
        check("R1 mon reset", int'(mon_byte), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", int'(busy), 0);

        // R4 inclusive boundaries
        run_one(90, 1, 0);
        check("R4 rate 90", int'(band_code), 'h00);
        run_one(91, 0, 0);
        check("R4 rate 91", int'(band_code), 'h10);
        run_one(1000, 2, 0);
        check("R4 rate 1000", int'(band_code), 'h1a);
        run_one(1100, 1, 0);
        check("R4 rate 1100", int'(band_code), 'h3a);

        // R2 exhaustive sweep over the listed range
        for (int r = 0; r <= 1510; r++) run_one(r, r % 4, 0);

        // R3 saturation well beyond the list
        run_one(1501, 0, 0);
        run_one(2047, 2, 0);
        run_one(4095, 1, 0);

        // R7 start pulses during search and during the write
        run_one(700, 3, 5);
        run_one(1500, 2, 20);
        run_one(95, 2, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule